// File: doc/BRIEF.md
# DRAM Refresh Interval Scheduler

This block produces the periodic refresh demand for one DRAM channel and shuts out all other traffic while a refresh runs. A free-running interval timer adds one owed refresh every refresh interval. The block raises `ref_req` while at least one refresh is owed and no refresh window is open. The command issuer answers with `ref_grant`. The request is taken only in a cycle where `ref_grant` and `banks_idle` are both high. From that cycle on, `inhibit` stays high for the refresh cycle time, and the command issuer must send nothing else while it is high.

The memory cells lose charge, so a refresh may be late but must never be dropped. Owed refreshes are therefore counted on `postponed_cnt`, up to a parameterised limit. If one more is owed when the count is already at that limit, a sticky `overflow` flag is set. The interval timer never pauses for a pending or running refresh, so the long-run refresh rate stays exact. Both intervals are given in controller clock cycles. The defaults, 3120 and 160 cycles at 800 MHz, model 3.9 us and 200 ns.

Top module: `refresh_sched`

## Requirements
- R1: Synchronous reset with `rst_n` low drives `ref_req`, `inhibit` and `overflow` to 0 and `postponed_cnt` to 0. This holds in the first cycle of reset and again when reset is applied after an overflow.
- R2: The first refresh becomes owed on the REFI_CYC-th rising edge after reset is released. Another one becomes owed every REFI_CYC edges after that. `ref_req` is first seen high after that edge.
- R3: A pending request is accepted only in a cycle where `ref_req`, `ref_grant` and `banks_idle` are all high. `ref_grant` without `banks_idle`, or `banks_idle` without `ref_grant`, leaves `ref_req` high, `inhibit` low and `postponed_cnt` unchanged.
- R4: `inhibit` is high for exactly RFC_CYC consecutive cycles after each accepted request. The accepting cycle itself is the first of those cycles, and `inhibit` rises in it without waiting for a clock edge.
- R5: `ref_req` is low in every cycle of the refresh window after the accepting cycle, even when refreshes are owed. It is high again in the first cycle after the window if `postponed_cnt` is nonzero.
- R6: `postponed_cnt` is the number of owed refreshes. An interval expiry adds one and an accepted request removes one. When both happen in the same cycle, the count is unchanged.
- R7: The interval timer keeps running during pending and active refreshes. With requests granted at once, the inhibited cycles over M whole intervals total exactly M*RFC_CYC out of M*REFI_CYC. That share is RFC_CYC/REFI_CYC, at least RFC_CYC/(REFI_CYC+RFC_CYC), about 5% with the defaults.
- R8: `postponed_cnt` never exceeds MAX_POSTPONE. An expiry that finds the count at MAX_POSTPONE with no accept in that cycle sets `overflow`, and `overflow` stays set until reset. A later grant still lowers the count, so an owed refresh is delayed and not lost.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Synchronous reset, active low |
| ref_grant | input | 1 | Command issuer grants the refresh slot |
| banks_idle | input | 1 | All banks are closed and a refresh may start |
| ref_req | output | 1 | Refresh owed and no window open |
| inhibit | output | 1 | Refresh window active; block all other commands |
| postponed_cnt | output | CW (4) | Number of owed refreshes |
| overflow | output | 1 | Sticky: a refresh was owed beyond MAX_POSTPONE |

## Verification
An interval expiry and an accepted grant can fall on the same clock edge. The bench provokes this by driving the grant one cycle before a known expiry edge, which it counts from reset release. It judges the result by checking that the owed count stays where it was while the refresh window opens. A second case places an expiry inside a running window: the count must rise while `ref_req` stays low, and the request must return as soon as the window closes.

// File: rtl/refresh_sched.sv
module refresh_sched #(
  parameter int REFI_CYC     = 3120,
  parameter int RFC_CYC      = 160,
  parameter int MAX_POSTPONE = 8,
  parameter int CW           = $clog2(MAX_POSTPONE + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ref_grant,
  input  logic          banks_idle,
  output logic          ref_req,
  output logic          inhibit,
  output logic [CW-1:0] postponed_cnt,
  output logic          overflow
);
  localparam int IW = $clog2(REFI_CYC + 1);
  localparam int RW = $clog2(RFC_CYC + 1);
  localparam logic [CW-1:0] CNT_MAX = CW'(MAX_POSTPONE);

  logic [IW-1:0] iv_cnt;
  logic [RW-1:0] win_cnt;
  logic [CW-1:0] owed;
  logic          tick, busy, accept, full;

  assign tick   = (iv_cnt == IW'(REFI_CYC - 1));
  assign busy   = (win_cnt != '0);
  assign full   = (owed == CNT_MAX);
  assign ref_req = (owed != '0) && !busy;
  assign accept = ref_req && ref_grant && banks_idle;
  assign inhibit = accept || busy;
  assign postponed_cnt = owed;

  always_ff @(posedge clk) begin
    if (!rst_n) iv_cnt <= '0;
    else        iv_cnt <= tick ? '0 : iv_cnt + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)      win_cnt <= '0;
    else if (accept) win_cnt <= RW'(RFC_CYC - 1);
    else if (busy)   win_cnt <= win_cnt - 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      owed     <= '0;
      overflow <= 1'b0;
    end else begin
      case ({tick, accept})
        2'b10:   if (!full) owed <= owed + 1'b1;
        2'b01:   owed <= owed - 1'b1;
        default: owed <= owed;
      endcase
      if (tick && full && !accept) overflow <= 1'b1;
    end
  end
endmodule

// File: rtl/refresh_sched_chk.sv
module refresh_sched_chk #(
  parameter int RFC_CYC      = 160,
  parameter int MAX_POSTPONE = 8,
  parameter int CW           = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic          ref_grant,
  input logic          banks_idle,
  input logic          ref_req,
  input logic          inhibit,
  input logic [CW-1:0] postponed_cnt,
  input logic          overflow
);
  localparam logic [CW-1:0] CNT_MAX = CW'(MAX_POSTPONE);

  assert_start_needs_both_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(inhibit) |-> (ref_grant && banks_idle));

  generate
    if (RFC_CYC > 1) begin : g_win
      assert_window_blocks_req_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (ref_req && ref_grant && banks_idle) |=> (inhibit && !ref_req));
    end
  endgenerate

  assert_req_iff_owed_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ref_req |-> (postponed_cnt != '0));

  assert_owed_idle_requests_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ((postponed_cnt != '0) && !inhibit) |-> ref_req);

  assert_cnt_steps_by_one_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (postponed_cnt == $past(postponed_cnt)) ||
    (postponed_cnt == $past(postponed_cnt) + 1'b1) ||
    (postponed_cnt == $past(postponed_cnt) - 1'b1));

  assert_cnt_bounded_R8: assert property (@(posedge clk) disable iff (!rst_n)
    postponed_cnt <= CNT_MAX);

  assert_overflow_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    overflow |=> overflow);
endmodule

bind refresh_sched refresh_sched_chk #(
  .RFC_CYC(RFC_CYC), .MAX_POSTPONE(MAX_POSTPONE), .CW(CW)
) u_chk (
  .clk(clk), .rst_n(rst_n), .ref_grant(ref_grant), .banks_idle(banks_idle),
  .ref_req(ref_req), .inhibit(inhibit), .postponed_cnt(postponed_cnt),
  .overflow(overflow)
);

// File: tb/sim_refresh_sched.sv
module sim_refresh_sched;
  localparam int CLK_NS = 10;
  localparam int REFI = 60;
  localparam int RFC = 7;
  localparam int MAXP = 8;
  localparam int CW = 4;
  localparam int M = 20;

  logic clk = 1'b0, rst_n = 1'b0, ref_grant = 1'b0, banks_idle = 1'b0;
  logic ref_req, inhibit, overflow;
  logic [CW-1:0] postponed_cnt;

  int checks = 0, errors = 0, pe = 0, run = 0, inh_total = 0;
  bit auto_g = 0, meas = 0, done = 0, nxt_g = 0, nxt_i = 0;
  int exp_q[$];

  refresh_sched #(.REFI_CYC(REFI), .RFC_CYC(RFC), .MAX_POSTPONE(MAXP), .CW(CW)) u0 (
    .clk(clk), .rst_n(rst_n), .ref_grant(ref_grant), .banks_idle(banks_idle),
    .ref_req(ref_req), .inhibit(inhibit), .postponed_cnt(postponed_cnt),
    .overflow(overflow));

  always #(CLK_NS/2) clk = ~clk;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d (pe=%0d)", req, act, exp, pe);
    end
  endtask

  task automatic step();
    @(negedge clk);
    pe++;
    #1;
    if (auto_g) begin
      ref_grant = ref_req;
      banks_idle = 1'b1;
    end else begin
      ref_grant = nxt_g;
      banks_idle = nxt_i;
    end
    if (rst_n && ref_grant && banks_idle && ref_req) exp_q.push_back(RFC);
    #1;
  endtask

  always @(negedge clk) begin
    #3;
    if (rst_n) begin
      if (meas && inhibit) inh_total++;
      if (inhibit) run++;
      else if (run > 0) begin
        if (exp_q.size() == 0) chk(1'b0, "R4 window without grant", run, 0);
        else begin
          int e;
          e = exp_q.pop_front();
          chk(run == e, "R4 window length", run, e);
        end
        run = 0;
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) step();
    chk(!ref_req && !inhibit && !overflow && postponed_cnt == 0, "R1 reset state",
        {ref_req, inhibit, overflow, postponed_cnt}, 0);
    rst_n = 1'b1;
    pe = 0;

    while (!ref_req && pe < REFI + 5) step();
    chk(pe == REFI, "R2 first request edge", pe, REFI);
    chk(postponed_cnt == 1, "R6 count after first expiry", postponed_cnt, 1);

    while (pe < 2*REFI - 1) step();
    chk(ref_req && postponed_cnt == 1, "R2 still one owed before second expiry", postponed_cnt, 1);
    step();
    chk(postponed_cnt == 2, "R2 second expiry after REFI edges", postponed_cnt, 2);

    nxt_g = 1; nxt_i = 0;
    repeat (5) begin
      step();
      chk(ref_req && !inhibit && postponed_cnt == 2, "R3 grant without banks_idle ignored",
          {ref_req, inhibit, postponed_cnt}, {1'b1, 1'b0, 4'd2});
    end
    nxt_g = 0; nxt_i = 1;
    repeat (3) begin
      step();
      chk(ref_req && !inhibit && postponed_cnt == 2, "R3 banks_idle without grant ignored",
          {ref_req, inhibit, postponed_cnt}, {1'b1, 1'b0, 4'd2});
    end

    nxt_g = 1; nxt_i = 1;
    step();
    chk(inhibit == 1, "R4 inhibit in accepting cycle", inhibit, 1);
    nxt_g = 0;
    step();
    chk(postponed_cnt == 1, "R6 accept lowers count", postponed_cnt, 1);
    while (inhibit) begin
      chk(ref_req == 0, "R5 request low in window", ref_req, 0);
      step();
    end
    chk(ref_req == 1, "R5 request returns after window", ref_req, 1);

    while (pe < 3*REFI - 2) step();
    nxt_g = 1; nxt_i = 1;
    step();
    nxt_g = 0;
    step();
    chk(pe == 3*REFI && postponed_cnt == 1, "R6 expiry and accept in same cycle", postponed_cnt, 1);
    chk(inhibit == 1, "R6 window opened on coincident edge", inhibit, 1);
    while (inhibit) step();

    while (pe < 4*REFI - 6) step();
    nxt_g = 1; nxt_i = 1;
    step();
    nxt_g = 0;
    while (pe < 4*REFI) step();
    chk(postponed_cnt == 1 && inhibit && !ref_req, "R7 expiry counted during window",
        postponed_cnt, 1);
    while (inhibit) step();
    chk(ref_req == 1, "R5 owed expiry requested after window", ref_req, 1);

    auto_g = 1;
    repeat (3*REFI) step();
    chk(postponed_cnt == 0, "R6 drained by prompt grants", postponed_cnt, 0);
    while (((pe + 1) % REFI) != 0) step();
    meas = 1;
    repeat (M*REFI) step();
    meas = 0;
    chk(inh_total == M*RFC, "R7 inhibited cycles over intervals", inh_total, M*RFC);
    chk(inh_total*(REFI + RFC) >= M*REFI*RFC, "R7 overhead at least RFC/(REFI+RFC)",
        inh_total*1000/(M*REFI), RFC*1000/(REFI + RFC));
    $display("refresh overhead %0d permille", inh_total*1000/(M*REFI));

    auto_g = 0; nxt_g = 0; nxt_i = 0;
    while (postponed_cnt != MAXP && pe < 20*REFI + 3000) step();
    chk(postponed_cnt == MAXP && !overflow, "R8 count reaches limit", postponed_cnt, MAXP);
    repeat (REFI - 1) step();
    chk(overflow == 0 && postponed_cnt == MAXP, "R8 no overflow before next expiry", overflow, 0);
    step();
    chk(overflow == 1, "R8 overflow on expiry at limit", overflow, 1);
    chk(postponed_cnt == MAXP, "R8 count saturates", postponed_cnt, MAXP);
    nxt_g = 1; nxt_i = 1;
    step();
    nxt_g = 0;
    step();
    chk(postponed_cnt == MAXP - 1, "R8 owed refresh still served", postponed_cnt, MAXP - 1);
    repeat (RFC + 2) step();
    chk(overflow == 1 && ref_req == 1, "R8 overflow sticky", overflow, 1);

    rst_n = 1'b0;
    step();
    chk(!overflow && postponed_cnt == 0 && !ref_req && !inhibit, "R1 reset clears overflow",
        {overflow, postponed_cnt}, 0);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule